// File: doc/BRIEF.md
# Sector-Staged Disk Command Interface

This block is a byte-wide, register-mapped front end for a sector-addressed disk. Software loads a cylinder (two bytes), a head and a sector number, then writes a command byte that asks for either a sector read or a sector write. All sector data passes through one data port, one byte per access, into or out of a 512-byte staging buffer inside the block.

A small on-chip backing store stands in for the media. Its geometry (cylinders, heads, sectors per track) and its access latency in clock cycles are parameters. A write commits only after all 512 bytes have been streamed in. A read fills the staging buffer from the store before completion is reported. When a command finishes, a ready flag is set and, if the command asked for it, an interrupt is raised that carries a programmable 8-bit vector. Addresses outside the configured geometry and malformed commands are reported through an error flag.

Register map (3-bit offset): 0 vector, 1 cylinder low byte, 2 cylinder high byte, 3 head, 4 sector, 5 command, 6 status, 7 data. Sector numbers start at 0.

Top module: `dsk_ctrl`

## Requirements
- R1: After reset the status register reads 0x00, the vector register reads 0x00 and `irq` is low.
- R2: The vector, cylinder low, cylinder high, head and sector registers read back the last value written to them.
- R3: A command byte with bit 1 set and bit 0 clear (write) accepts exactly 512 data-port writes. After the 512th byte, the sector is committed to the backing store and status bit 0 (ready) sets with status bit 1 (error) clear.
- R4: A command byte with bit 0 set and bit 1 clear (read) sets ready exactly LATENCY+512 clock cycles after the command write. Ready is not set one cycle earlier. The 512 following data-port reads then return the stored sector bytes in order.
- R5: Accepting any command clears ready.
- R6: A command byte with both bit 0 and bit 1 set leaves ready clear, sets error, raises no interrupt and starts no transfer.
- R7: A read or write whose cylinder, head or sector is outside the configured geometry shows status 0x03 (ready and error) on the cycle after the command write.
- R8: When command bit 4 was set, completion raises `irq` with `irq_vec` equal to the vector register. The request stays up until the status register is read with `reg_rd` high, and it drops on the next cycle.
- R9: When command bit 4 was clear, completion sets ready but leaves `irq` low.
- R10: Data-port writes are ignored outside the 512-byte write phase, so the contents of a buffer filled by a read are not altered by them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; enables read side effects (data pointer advance, interrupt clear) |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| irq | output | 1 | Interrupt request |
| irq_vec | output | 8 | Interrupt vector value |

## Verification
A corrupted sequencer state or latency counter shows up at the status port as ready arriving early or late. The bench checks this to the exact cycle, LATENCY+512 cycles after a read command. A wrong byte pointer or a wrong sector index shows up as mismatched bytes on the first data-port read of a read-back sector, and those bytes are compared against patterns that were written to different sectors. A wrong interrupt flag becomes visible within one cycle of completion, or within one cycle of a status read.

// File: rtl/dsk_pkg.sv
// Shared definitions for the disk command interface: register offsets,
// bit positions and sequencer states. Assumes a fixed 512-byte sector.
package dsk_pkg;
    localparam int SECTOR_BYTES = 512;
    localparam int PTR_W        = 9;

    typedef enum logic [2:0] {
        RA_VEC    = 3'd0,
        RA_CYL_LO = 3'd1,
        RA_CYL_HI = 3'd2,
        RA_HEAD   = 3'd3,
        RA_SECT   = 3'd4,
        RA_CMD    = 3'd5,
        RA_STAT   = 3'd6,
        RA_DATA   = 3'd7
    } reg_addr_e;

    localparam int CMD_RD_BIT  = 0;
    localparam int CMD_WR_BIT  = 1;
    localparam int CMD_IEN_BIT = 4;

    typedef enum logic [1:0] {
        SQ_IDLE = 2'd0,
        SQ_FILL = 2'd1,
        SQ_WAIT = 2'd2,
        SQ_COPY = 2'd3
    } seq_state_e;
endpackage

// File: rtl/dsk_sector_buf.sv
// 512-byte staging buffer. One port serves the host (byte pointer) and the
// other serves the sector copy engine. Both reads are combinational.
// Assumes the two write enables are never high in the same cycle.
module dsk_sector_buf
    import dsk_pkg::*;
(
    input  logic             clk,
    input  logic             host_we,
    input  logic [PTR_W-1:0] host_idx,
    input  logic [7:0]       host_wdata,
    output logic [7:0]       host_rdata,
    input  logic             copy_we,
    input  logic [PTR_W-1:0] copy_idx,
    input  logic [7:0]       copy_wdata,
    output logic [7:0]       copy_rdata
);
    logic [7:0] mem [SECTOR_BYTES];

    // Store one byte from whichever side is writing.
    always_ff @(posedge clk) begin
        if (host_we)
            mem[host_idx] <= host_wdata;
        else if (copy_we)
            mem[copy_idx] <= copy_wdata;
    end

    assign host_rdata = mem[host_idx];
    assign copy_rdata = mem[copy_idx];
endmodule

// File: rtl/dsk_media.sv
// Backing store that stands in for the disk surface: NSECT sectors of 512
// bytes, one byte per cycle, combinational read. Contents are not reset.
module dsk_media #(
    parameter int NSECT = 4,
    localparam int AW   = $clog2(NSECT * dsk_pkg::SECTOR_BYTES)
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [7:0]    wdata,
    output logic [7:0]    rdata
);
    logic [7:0] mem [NSECT * dsk_pkg::SECTOR_BYTES];

    // Commit a byte to the store.
    always_ff @(posedge clk) begin
        if (we) mem[addr] <= wdata;
    end

    assign rdata = mem[addr];
endmodule

// File: rtl/dsk_seq.sv
// Command sequencer. It collects 512 host bytes for a write, waits LATENCY
// cycles to model media access, then copies a sector (store to buffer, or
// buffer to store) one byte per cycle. Assumes LATENCY >= 1.
module dsk_seq
    import dsk_pkg::*;
#(
    parameter int LATENCY = 16,
    localparam int CNT_W  = $clog2(LATENCY + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_rd,
    input  logic             start_wr,
    input  logic             fill_last,
    output seq_state_e       state,
    output logic [PTR_W-1:0] copy_idx,
    output logic             to_media,
    output logic             done
);
    localparam logic [CNT_W-1:0] CNT_END = CNT_W'(LATENCY - 1);
    localparam logic [PTR_W-1:0] IDX_END = PTR_W'(SECTOR_BYTES - 1);

    seq_state_e       state_q;
    logic [CNT_W-1:0] cnt_q;
    logic [PTR_W-1:0] idx_q;
    logic             dir_q;

    // State transitions, latency count and copy index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= SQ_IDLE;
            cnt_q   <= '0;
            idx_q   <= '0;
            dir_q   <= 1'b0;
        end else begin
            case (state_q)
                SQ_IDLE: begin
                    if (start_rd) begin
                        state_q <= SQ_WAIT;
                        cnt_q   <= '0;
                        dir_q   <= 1'b0;
                    end else if (start_wr) begin
                        state_q <= SQ_FILL;
                        dir_q   <= 1'b1;
                    end
                end
                SQ_FILL: begin
                    if (fill_last) begin
                        state_q <= SQ_WAIT;
                        cnt_q   <= '0;
                    end
                end
                SQ_WAIT: begin
                    if (cnt_q == CNT_END) begin
                        state_q <= SQ_COPY;
                        idx_q   <= '0;
                    end else begin
                        cnt_q <= cnt_q + 1'b1;
                    end
                end
                SQ_COPY: begin
                    idx_q <= idx_q + 1'b1;
                    if (idx_q == IDX_END) state_q <= SQ_IDLE;
                end
                default: state_q <= SQ_IDLE;
            endcase
        end
    end

    assign state    = state_q;
    assign copy_idx = idx_q;
    assign to_media = dir_q;
    assign done     = (state_q == SQ_COPY) && (idx_q == IDX_END);
endmodule

// File: rtl/dsk_ctrl.sv
// Top of the disk command interface: register file, host byte pointer,
// geometry check, status and interrupt logic around the sequencer, the
// staging buffer and the backing store. Commands arriving while a transfer
// is running are ignored.
module dsk_ctrl
    import dsk_pkg::*;
#(
    parameter int CYLS    = 2,
    parameter int HEADS   = 1,
    parameter int SECTS   = 2,
    parameter int LATENCY = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [2:0] reg_addr,
    input  logic       reg_wr,
    input  logic       reg_rd,
    input  logic [7:0] reg_wdata,
    output logic [7:0] reg_rdata,
    output logic       irq,
    output logic [7:0] irq_vec
);
    localparam int NSECT = CYLS * HEADS * SECTS;
    localparam int LIN_W = (NSECT > 1) ? $clog2(NSECT) : 1;
    localparam int MAW   = $clog2(NSECT * SECTOR_BYTES);
    localparam logic [15:0] CYL_LIM  = 16'(CYLS);
    localparam logic [7:0]  HEAD_LIM = 8'(HEADS);
    localparam logic [7:0]  SECT_LIM = 8'(SECTS);
    localparam logic [PTR_W-1:0] PTR_END = PTR_W'(SECTOR_BYTES - 1);

    logic [7:0]       vec_q, cyl_lo_q, cyl_hi_q, head_q, sect_q;
    logic             ien_q, ready_q, error_q, irq_q;
    logic [PTR_W-1:0] ptr_q;
    logic [LIN_W-1:0] lin_q;

    seq_state_e       state;
    logic [PTR_W-1:0] copy_idx;
    logic             to_media, done, busy;
    logic [15:0]      cyl;
    logic             in_range, one_op, both_op, cmd_acc, go_rd, go_wr;
    logic             host_we, fill_last, data_rd;
    logic [LIN_W-1:0] lin_idx;
    logic [7:0]       buf_host_rd, buf_copy_rd, media_rd;

    assign busy     = (state != SQ_IDLE);
    assign cyl      = {cyl_hi_q, cyl_lo_q};
    assign in_range = (cyl < CYL_LIM) && (head_q < HEAD_LIM) && (sect_q < SECT_LIM);
    assign lin_idx  = LIN_W'((32'(cyl) * 32'(HEADS) + 32'(head_q)) * 32'(SECTS) + 32'(sect_q));
    assign cmd_acc  = reg_wr && (reg_addr == RA_CMD) && !busy;
    assign one_op   = reg_wdata[CMD_RD_BIT] ^ reg_wdata[CMD_WR_BIT];
    assign both_op  = reg_wdata[CMD_RD_BIT] & reg_wdata[CMD_WR_BIT];
    assign go_rd    = cmd_acc && one_op && reg_wdata[CMD_RD_BIT] && in_range;
    assign go_wr    = cmd_acc && one_op && reg_wdata[CMD_WR_BIT] && in_range;
    assign host_we  = reg_wr && (reg_addr == RA_DATA) && (state == SQ_FILL);
    assign fill_last = host_we && (ptr_q == PTR_END);
    assign data_rd  = reg_rd && (reg_addr == RA_DATA) && !busy;

    // Address and vector registers: plain byte stores.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vec_q <= '0; cyl_lo_q <= '0; cyl_hi_q <= '0; head_q <= '0; sect_q <= '0;
        end else if (reg_wr) begin
            case (reg_addr)
                RA_VEC:    vec_q    <= reg_wdata;
                RA_CYL_LO: cyl_lo_q <= reg_wdata;
                RA_CYL_HI: cyl_hi_q <= reg_wdata;
                RA_HEAD:   head_q   <= reg_wdata;
                RA_SECT:   sect_q   <= reg_wdata;
                default: ;
            endcase
        end
    end

    // Status, interrupt, host byte pointer and latched sector index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ien_q <= 1'b0; ready_q <= 1'b0; error_q <= 1'b0; irq_q <= 1'b0;
            ptr_q <= '0;   lin_q   <= '0;
        end else begin
            if (reg_rd && (reg_addr == RA_STAT)) irq_q <= 1'b0;
            if (host_we || data_rd) ptr_q <= ptr_q + 1'b1;
            if (cmd_acc) begin
                ien_q   <= reg_wdata[CMD_IEN_BIT];
                ptr_q   <= '0;
                lin_q   <= lin_idx;
                error_q <= both_op || (one_op && !in_range);
                ready_q <= one_op && !in_range;
                irq_q   <= one_op && !in_range && reg_wdata[CMD_IEN_BIT];
            end
            if (done) begin
                ready_q <= 1'b1;
                irq_q   <= ien_q;
                ptr_q   <= '0;
            end
        end
    end

    dsk_seq #(.LATENCY(LATENCY)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_rd(go_rd), .start_wr(go_wr),
        .fill_last(fill_last), .state(state), .copy_idx(copy_idx),
        .to_media(to_media), .done(done)
    );

    dsk_sector_buf u_buf (
        .clk(clk),
        .host_we(host_we), .host_idx(ptr_q), .host_wdata(reg_wdata), .host_rdata(buf_host_rd),
        .copy_we((state == SQ_COPY) && !to_media), .copy_idx(copy_idx),
        .copy_wdata(media_rd), .copy_rdata(buf_copy_rd)
    );

    dsk_media #(.NSECT(NSECT)) u_media (
        .clk(clk), .we((state == SQ_COPY) && to_media),
        .addr(MAW'({lin_q, copy_idx})), .wdata(buf_copy_rd), .rdata(media_rd)
    );

    // Read-data multiplexer.
    always_comb begin
        case (reg_addr)
            RA_VEC:    reg_rdata = vec_q;
            RA_CYL_LO: reg_rdata = cyl_lo_q;
            RA_CYL_HI: reg_rdata = cyl_hi_q;
            RA_HEAD:   reg_rdata = head_q;
            RA_SECT:   reg_rdata = sect_q;
            RA_CMD:    reg_rdata = {3'b000, ien_q, 4'b0000};
            RA_STAT:   reg_rdata = {6'b0, error_q, ready_q};
            default:   reg_rdata = buf_host_rd;
        endcase
    end

    assign irq     = irq_q;
    assign irq_vec = vec_q;
endmodule

// File: rtl/dsk_ctrl_chk.sv
// Property checker for dsk_ctrl. It watches the register strobes against
// the internal status flags and is attached to every dsk_ctrl by bind.
module dsk_ctrl_chk
    import dsk_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] reg_addr,
    input logic       reg_wr,
    input logic       reg_rd,
    input logic [7:0] reg_wdata,
    input logic       irq,
    input logic       ready,
    input logic       error,
    input logic       ien,
    input logic       busy
);
    AST_IRQ_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ready); // R8

    AST_IRQ_STATUS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && reg_rd && reg_addr == RA_STAT && !reg_wr) |=> !irq); // R8

    AST_BADCMD_ERROR: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CMD && !busy && reg_wdata[1:0] == 2'b11) |=> (error && !ready && !irq)); // R6

    AST_CMD_CLEARS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && reg_addr == RA_CMD && !busy) |=> (!ready || error)); // R5

    AST_IRQ_ONLY_ENABLED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> ien); // R9
endmodule

bind dsk_ctrl dsk_ctrl_chk u_chk (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_rd(reg_rd), .reg_wdata(reg_wdata), .irq(irq_q), .ready(ready_q),
    .error(error_q), .ien(ien_q), .busy(busy)
);

// File: tb/sim_dsk_ctrl.sv
// Directed bench for dsk_ctrl: one task per scenario, each checking itself.
module sim_dsk_ctrl;
    localparam int LAT = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] reg_addr = '0;
    logic       reg_wr = 1'b0, reg_rd = 1'b0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata, irq_vec;
    logic       irq;
    int checks = 0, failures = 0;
    bit finished = 0;

    dsk_ctrl #(.CYLS(2), .HEADS(1), .SECTS(2), .LATENCY(LAT)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_rd(reg_rd), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .irq(irq), .irq_vec(irq_vec)
    );

    always #2 clk = ~clk;

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int k, input int i);
        return 8'(i * 7 + k * 29 + 3);
    endfunction

    task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk); reg_wr = 1'b0;
    endtask

    task automatic peek(input logic [2:0] a, output logic [7:0] v);
        reg_addr = a; #1 v = reg_rdata;
    endtask

    task automatic set_chs(input logic [15:0] c, input logic [7:0] h, input logic [7:0] s);
        wr_reg(3'd1, c[7:0]); wr_reg(3'd2, c[15:8]); wr_reg(3'd3, h); wr_reg(3'd4, s);
    endtask

    task automatic wait_ready(input string req);
        logic [7:0] st = 8'h00;
        for (int n = 0; n < LAT + 700; n++) begin
            peek(3'd6, st);
            if (st[0]) break;
            @(negedge clk);
        end
        check(st == 8'h01, req, st, 8'h01);
    endtask

    // Stream the buffer out through the data port and compare with sector k.
    task automatic read_out(input int k, input string req);
        int bad = 0;
        logic [7:0] v;
        for (int i = 0; i < 512; i++) begin
            @(negedge clk); reg_addr = 3'd7; reg_rd = 1'b1;
            #1 v = reg_rdata;
            if (v != pat(k, i)) bad++;
        end
        @(negedge clk); reg_rd = 1'b0;
        check(bad == 0, req, bad, 0);
    endtask

    task automatic t_reset;
        logic [7:0] v;
        peek(3'd6, v); check(v == 8'h00, "R1 status", v, 0);
        peek(3'd0, v); check(v == 8'h00, "R1 vector", v, 0);
        check(irq == 1'b0, "R1 irq", irq, 0);
    endtask

    task automatic t_regs;
        logic [7:0] v;
        wr_reg(3'd0, 8'h5A); wr_reg(3'd1, 8'hC3); wr_reg(3'd2, 8'h12);
        wr_reg(3'd3, 8'h07); wr_reg(3'd4, 8'h99);
        peek(3'd0, v); check(v == 8'h5A, "R2 vector", v, 8'h5A);
        peek(3'd1, v); check(v == 8'hC3, "R2 cyl lo", v, 8'hC3);
        peek(3'd2, v); check(v == 8'h12, "R2 cyl hi", v, 8'h12);
        peek(3'd3, v); check(v == 8'h07, "R2 head", v, 8'h07);
        peek(3'd4, v); check(v == 8'h99, "R2 sector", v, 8'h99);
    endtask

    task automatic t_write(input logic [15:0] c, input logic [7:0] s, input int k);
        set_chs(c, 8'h00, s);
        wr_reg(3'd5, 8'h02);
        for (int i = 0; i < 512; i++) begin
            @(negedge clk); reg_addr = 3'd7; reg_wdata = pat(k, i); reg_wr = 1'b1;
        end
        @(negedge clk); reg_wr = 1'b0;
        wait_ready("R3 write commit");
    endtask

    task automatic t_read_timed(input logic [15:0] c, input logic [7:0] s, input int k);
        logic [7:0] v;
        set_chs(c, 8'h00, s);
        wr_reg(3'd5, 8'h01);
        repeat (LAT + 511) @(negedge clk);
        peek(3'd6, v); check(v[0] == 1'b0, "R4 not ready early", v, 0);
        @(negedge clk);
        peek(3'd6, v); check(v == 8'h01, "R4 ready on time", v, 1);
        check(irq == 1'b0, "R9 no irq when disabled", irq, 0);
        read_out(k, "R4/R3 read data");
    endtask

    task automatic t_ready_clear;
        logic [7:0] v;
        set_chs(16'd0, 8'h00, 8'h00);
        wr_reg(3'd5, 8'h01);
        peek(3'd6, v); check(v == 8'h00, "R5 ready cleared", v, 0);
        wait_ready("R5 completes");
        wr_reg(3'd7, 8'hEE); wr_reg(3'd7, 8'hEE); wr_reg(3'd7, 8'hEE);
        read_out(0, "R10 data writes ignored");
    endtask

    task automatic t_badcmd;
        logic [7:0] v;
        wr_reg(3'd5, 8'h13);
        peek(3'd6, v); check(v == 8'h02, "R6 bad command status", v, 2);
        repeat (LAT + 520) @(negedge clk);
        peek(3'd6, v); check(v == 8'h02, "R6 no transfer", v, 2);
        check(irq == 1'b0, "R6 no irq", irq, 0);
    endtask

    task automatic t_range;
        logic [7:0] v;
        set_chs(16'd9, 8'h00, 8'h00);
        wr_reg(3'd5, 8'h11);
        peek(3'd6, v); check(v == 8'h03, "R7 range status", v, 3);
        check(irq == 1'b1, "R7 irq on range error", irq, 1);
        @(negedge clk); reg_addr = 3'd6; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        check(irq == 1'b0, "R8 irq cleared by status read", irq, 0);
        set_chs(16'd0, 8'h00, 8'h05);
        wr_reg(3'd5, 8'h02);
        peek(3'd6, v); check(v == 8'h03, "R7 sector range", v, 3);
    endtask

    task automatic t_irq;
        logic [7:0] v;
        wr_reg(3'd0, 8'h0A);
        set_chs(16'd1, 8'h00, 8'h01);
        wr_reg(3'd5, 8'h11);
        wait_ready("R8 completes");
        check(irq == 1'b1, "R8 irq raised", irq, 1);
        check(irq_vec == 8'h0A, "R8 vector", irq_vec, 8'h0A);
        peek(3'd6, v);
        @(negedge clk);
        check(irq == 1'b1, "R8 held without strobe", irq, 1);
        @(negedge clk); reg_addr = 3'd6; reg_rd = 1'b1;
        @(negedge clk); reg_rd = 1'b0;
        check(irq == 1'b0, "R8 cleared", irq, 0);
        read_out(1, "R8 read data");
    endtask

    initial begin
        #(4 * 150000);
        if (!finished) begin
            failures++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_write(16'd0, 8'h00, 0);
        t_write(16'd1, 8'h01, 1);
        t_read_timed(16'd0, 8'h00, 0);
        t_read_timed(16'd1, 8'h01, 1);
        t_ready_clear();
        t_badcmd();
        t_range();
        t_irq();
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule